// File: doc/BRIEF.md
# Dual-Mode Programmable Synthesizer Divider

This block is the digital divider chain of a frequency synthesizer. It counts pulses of a local-oscillator input and emits one output pulse, `fp`, for every N of them. N comes from a 16-bit ratio word. Two mode flags pick how N is formed and counted. One choice is a pulse-swallow structure: a modelled 16/17 dual-modulus prescaler plus a swallow counter. The other is a direct 12-bit counter that takes its ratio from the upper twelve bits of the word. Both strobes feed a phase comparator that lies outside this block.

A second chain divides crystal ticks down to a reference pulse, `fr`. A 4-bit code picks one of fourteen coded rates. A crystal-select bit tells the block whether the crystal runs at 7.2 MHz or 4.5 MHz, and the division ratio is derived for either crystal so that the reference rate stays the same. The two top codes inhibit the loop and halt both chains. One of them also signals that the oscillator should stop. Both input strobes are single-cycle enables in the system clock domain.

Top module: `pll_divider_top`

## Requirements
- R1: While `rst` is high, `fp` and `fr` are low. Reset loads the ratio and mode present at the inputs, so the first `fp` follows the N-th counted oscillator tick after release.
- R2: With `fm_sel`=1 the pulse-swallow path is used whatever `am_swallow` is. N = `ratio_word`[15:0], bit 0 is the LSB, and there is one `fp` per N oscillator ticks for N in 272..65535.
- R3: With `fm_sel`=0 and `am_swallow`=1 the pulse-swallow path is used with the same N = `ratio_word`[15:0] and the same range of 272..65535.
- R4: With `fm_sel`=0 and `am_swallow`=0 the direct path is used. N = `ratio_word`[15:4] with bit 4 as the LSB, for a range of 4..4095, and `ratio_word`[3:0] has no effect.
- R5: A change of ratio word or mode flags during an output period takes effect only after the next `fp`. The period in progress completes with its old N.
- R6: `fr` occurs once per (crystal Hz / coded rate) crystal ticks. `xtal_hi`=1 means 7.2 MHz and 0 means 4.5 MHz. The code values in kHz are: 0000=100, 0001=50, 0010=25, 0011=25, 0100=12.5, 0101=6.25, 0110=3.125, 0111=3.125, 1000=10, 1001=9, 1010=5, 1011=1, 1100=3, 1101=30.
- R7: `ref_code` 1110 or 1111 sets `pll_off`. While it is set, `fp` and `fr` stay low and both counters are held cleared, so counting restarts from zero on release. `osc_stop` is high only for code 1110.
- R8: `fp` and `fr` are one-cycle pulses. Each appears in the cycle after the clock edge that samples the terminal tick, and cycles without a tick do not advance the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_tick | input | 1 | One-cycle enable per local-oscillator pulse |
| xtal_tick | input | 1 | One-cycle enable per crystal pulse |
| ratio_word | input | 16 | Division ratio word |
| fm_sel | input | 1 | 1 selects the high-band swallow path |
| am_swallow | input | 1 | With fm_sel=0: 1 swallow path, 0 direct path |
| ref_code | input | 4 | Reference rate / inhibit code |
| xtal_hi | input | 1 | 1 = 7.2 MHz crystal, 0 = 4.5 MHz |
| fp | output | 1 | Divided oscillator pulse |
| fr | output | 1 | Reference pulse |
| pll_off | output | 1 | Loop inhibited |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
The hardest situation to reach is a ratio or mode change that lands inside an output period. The change must not shorten that period and must govern the next one. The stimulus first synchronises to an `fp` pulse, then alters the word a few ticks later. It measures the interval in progress against the old N and the following interval against the new N, and does this for both a ratio change and a change of mode. Release from inhibit is also checked by counting ticks to the first pulse of each chain.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    localparam int RATIO_W   = 16;
    localparam int SWALLOW_W = 4;
    localparam int MAIN_W    = RATIO_W - SWALLOW_W;
    localparam int CODE_W    = 4;
    localparam int CODE_N    = 1 << CODE_W;
    localparam int MIN_RATE_HZ = 1000;

    typedef enum logic [1:0] {
        MODE_HI_SWALLOW = 2'd0,
        MODE_LO_SWALLOW = 2'd1,
        MODE_DIRECT     = 2'd2
    } div_mode_e;

    typedef struct packed {
        div_mode_e          mode;
        logic [RATIO_W-1:0] word;
    } div_cfg_t;

    function automatic div_mode_e decode_mode(input logic hi_band, input logic swallow);
        if (hi_band)      return MODE_HI_SWALLOW;
        else if (swallow) return MODE_LO_SWALLOW;
        else              return MODE_DIRECT;
    endfunction

    function automatic logic code_inhibits(input logic [CODE_W-1:0] code);
        return code[CODE_W-1:1] == 3'b111;
    endfunction

    // Coded reference rate in Hz, 0 for inhibit codes.
    function automatic int unsigned ref_rate_hz(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:       return 100000;
            4'd1:       return 50000;
            4'd2, 4'd3: return 25000;
            4'd4:       return 12500;
            4'd5:       return 6250;
            4'd6, 4'd7: return 3125;
            4'd8:       return 10000;
            4'd9:       return 9000;
            4'd10:      return 5000;
            4'd11:      return 1000;
            4'd12:      return 3000;
            4'd13:      return 30000;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider
    import pll_div_pkg::*;
#(
    parameter int unsigned XTAL_LO_HZ = 4500000,
    parameter int unsigned XTAL_HI_HZ = 7200000
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    input  logic              xtal_hi,
    output logic              fr
);
    localparam int unsigned XTAL_MAX = (XTAL_HI_HZ > XTAL_LO_HZ) ? XTAL_HI_HZ : XTAL_LO_HZ;
    localparam int CNT_W = $clog2(XTAL_MAX / MIN_RATE_HZ + 1);

    logic [CNT_W-1:0] lim_lo [CODE_N];
    logic [CNT_W-1:0] lim_hi [CODE_N];

    for (genvar c = 0; c < CODE_N; c++) begin : g_lim
        localparam int unsigned RATE = ref_rate_hz(CODE_W'(c));
        assign lim_lo[c] = CNT_W'((RATE == 0) ? 0 : XTAL_LO_HZ / RATE - 1);
        assign lim_hi[c] = CNT_W'((RATE == 0) ? 0 : XTAL_HI_HZ / RATE - 1);
    end

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             term;

    assign lim  = xtal_hi ? lim_hi[code] : lim_lo[code];
    assign term = tick && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (clear) begin
            cnt <= '0;
            fr  <= 1'b0;
        end else begin
            fr <= term;
            if (term)      cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/direct_divider.sv
module direct_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] n_val,
    output logic         term
);
    logic [W-1:0] cnt;

    assign term = tick && (({1'b0, cnt} + 1'b1) >= {1'b0, n_val});

    always_ff @(posedge clk) begin
        if (clear)     cnt <= '0;
        else if (term) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
    parameter int MAIN_W = 12,
    parameter int SW_W   = 4
) (
    input  logic                   clk,
    input  logic                   clear,
    input  logic                   tick,
    input  logic [MAIN_W+SW_W-1:0] n_val,
    output logic                   term
);
    localparam int PRE_W   = SW_W + 1;
    localparam int PRE_LEN = 1 << SW_W;

    logic [MAIN_W-1:0] main_lim;
    logic [SW_W-1:0]   sw_lim;
    logic [PRE_W-1:0]  pre_cnt;
    logic [MAIN_W-1:0] main_cnt;
    logic [SW_W-1:0]   sw_cnt;
    logic              extra;
    logic              pre_out;

    assign main_lim = n_val[MAIN_W+SW_W-1:SW_W];
    assign sw_lim   = n_val[SW_W-1:0];
    // Modulus PRE_LEN+1 while swallow count remains, else PRE_LEN.
    assign extra    = sw_cnt < sw_lim;
    assign pre_out  = tick && (pre_cnt == (extra ? PRE_W'(PRE_LEN) : PRE_W'(PRE_LEN - 1)));
    assign term     = pre_out && (({1'b0, main_cnt} + 1'b1) >= {1'b0, main_lim});

    always_ff @(posedge clk) begin
        if (clear || term) begin
            pre_cnt  <= '0;
            main_cnt <= '0;
            sw_cnt   <= '0;
        end else if (pre_out) begin
            pre_cnt  <= '0;
            main_cnt <= main_cnt + 1'b1;
            if (extra) sw_cnt <= sw_cnt + 1'b1;
        end else if (tick) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pll_divider_top.sv
module pll_divider_top
    import pll_div_pkg::*;
#(
    parameter int unsigned XTAL_LO_HZ = 4500000,
    parameter int unsigned XTAL_HI_HZ = 7200000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lo_tick,
    input  logic        xtal_tick,
    input  logic [15:0] ratio_word,
    input  logic        fm_sel,
    input  logic        am_swallow,
    input  logic [3:0]  ref_code,
    input  logic        xtal_hi,
    output logic        fp,
    output logic        fr,
    output logic        pll_off,
    output logic        osc_stop
);
    div_cfg_t cfg;
    div_cfg_t cfg_next;
    logic     inhibit;
    logic     use_direct;
    logic     term_sw;
    logic     term_dir;
    logic     term_any;

    assign inhibit    = code_inhibits(ref_code);
    assign cfg_next   = '{mode: decode_mode(fm_sel, am_swallow), word: ratio_word};
    assign use_direct = (cfg.mode == MODE_DIRECT);
    assign term_any   = use_direct ? term_dir : term_sw;

    swallow_divider #(.MAIN_W(MAIN_W), .SW_W(SWALLOW_W)) u_swallow (
        .clk   (clk),
        .clear (rst || inhibit || use_direct),
        .tick  (lo_tick),
        .n_val (cfg.word),
        .term  (term_sw)
    );

    direct_divider #(.W(MAIN_W)) u_direct (
        .clk   (clk),
        .clear (rst || inhibit || !use_direct),
        .tick  (lo_tick),
        .n_val (cfg.word[RATIO_W-1:SWALLOW_W]),
        .term  (term_dir)
    );

    ref_divider #(.XTAL_LO_HZ(XTAL_LO_HZ), .XTAL_HI_HZ(XTAL_HI_HZ)) u_ref (
        .clk     (clk),
        .clear   (rst || inhibit),
        .tick    (xtal_tick),
        .code    (ref_code),
        .xtal_hi (xtal_hi),
        .fr      (fr)
    );

    // Ratio and mode are sampled only at a terminal count, or while idle.
    always_ff @(posedge clk) begin
        if (rst || inhibit) begin
            cfg <= cfg_next;
            fp  <= 1'b0;
        end else begin
            fp <= term_any;
            if (term_any) cfg <= cfg_next;
        end
    end

    assign pll_off  = inhibit;
    assign osc_stop = (ref_code == 4'b1110);
endmodule

// File: rtl/pll_divider_chk.sv
module pll_divider_chk (
    input logic clk,
    input logic rst,
    input logic lo_tick,
    input logic xtal_tick,
    input logic fp,
    input logic fr,
    input logic pll_off
);
    assert_fp_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        fp |-> $past(lo_tick));

    assert_fr_after_tick_R8: assert property (@(posedge clk) disable iff (rst)
        fr |-> $past(xtal_tick));

    assert_inhibit_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        pll_off |=> (!fp && !fr));

    assert_fr_single_R6: assert property (@(posedge clk) disable iff (rst)
        fr |=> !fr);
endmodule

bind pll_divider_top pll_divider_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .lo_tick   (lo_tick),
    .xtal_tick (xtal_tick),
    .fp        (fp),
    .fr        (fr),
    .pll_off   (pll_off)
);

// File: tb/pll_divider_top_tb_top.sv
module pll_divider_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lo_tick = 1'b0;
    logic        xtal_tick = 1'b1;
    logic [15:0] ratio_word = 16'h0050;
    logic        fm_sel = 1'b0;
    logic        am_swallow = 1'b0;
    logic [3:0]  ref_code = 4'b0000;
    logic        xtal_hi = 1'b0;
    logic        fp, fr, pll_off, osc_stop;
    logic        lo_half = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pll_divider_top dut_i (
        .clk(clk), .rst(rst), .lo_tick(lo_tick), .xtal_tick(xtal_tick),
        .ratio_word(ratio_word), .fm_sel(fm_sel), .am_swallow(am_swallow),
        .ref_code(ref_code), .xtal_hi(xtal_hi),
        .fp(fp), .fr(fr), .pll_off(pll_off), .osc_stop(osc_stop)
    );

    always @(negedge clk) lo_tick <= lo_half ? ~lo_tick : 1'b1;

    // {fm_sel, am_swallow, ratio_word, expected period}
    localparam int VEC_N = 8;
    localparam logic [35:0] VEC [VEC_N] = '{
        {1'b1, 1'b0, 16'd272,  18'd272},
        {1'b1, 1'b1, 16'd1000, 18'd1000},
        {1'b0, 1'b1, 16'd300,  18'd300},
        {1'b0, 1'b1, 16'd4111, 18'd4111},
        {1'b0, 1'b0, 16'h0050, 18'd5},
        {1'b0, 1'b0, 16'h0FFF, 18'd255},
        {1'b0, 1'b0, 16'hFFF0, 18'd4095},
        {1'b1, 1'b0, 16'd1999, 18'd1999}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wait_fp();
        for (int n = 0; n < 70000; n++) begin
            @(negedge clk);
            if (fp) return;
        end
        check(1'b0, "fp timeout", 0, 1);
    endtask

    task automatic wait_fr();
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            if (fr) return;
        end
        check(1'b0, "fr timeout", 0, 1);
    endtask

    task automatic fp_interval(output int per);
        per = 0;
        for (int n = 0; n < 70000; n++) begin
            @(negedge clk);
            per++;
            if (fp) return;
        end
    endtask

    task automatic fr_interval(output int per);
        per = 0;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            per++;
            if (fr) return;
        end
    endtask

    task automatic ref_case(input logic [3:0] code, input logic hi, input int exp);
        int per;
        @(negedge clk);
        ref_code = code;
        xtal_hi  = hi;
        wait_fr();
        fr_interval(per);
        check(per == exp, "R6 reference ratio", per, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                check(1'b0, "watchdog", cyc, 190000);
                finish_run();
            end
        end
    end

    initial begin
        int per, first_fp, first_fr, nfp, nfr;
        string tag;

        // R1: reset state and first pulse after release
        repeat (5) @(negedge clk);
        check(fp == 1'b0 && fr == 1'b0, "R1 outputs low in reset", int'(fp) + int'(fr), 0);
        rst = 1'b0;
        first_fp = 0;
        first_fr = 0;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (fp && first_fp == 0) first_fp = n;
            if (fr && first_fr == 0) first_fr = n;
        end
        check(first_fp == 5, "R1 first fp after reset", first_fp, 5);
        check(first_fr == 45, "R6 first fr at 4.5 MHz 100 kHz", first_fr, 45);

        // Table of divider modes (R2, R3, R4)
        for (int i = 0; i < VEC_N; i++) begin
            @(negedge clk);
            fm_sel     = VEC[i][35];
            am_swallow = VEC[i][34];
            ratio_word = VEC[i][33:18];
            tag = VEC[i][35] ? "R2 high-band swallow" :
                  (VEC[i][34] ? "R3 low-band swallow" : "R4 direct");
            wait_fp();
            fp_interval(per);
            check(per == int'(VEC[i][17:0]), tag, per, int'(VEC[i][17:0]));
        end

        // R8: ticks only every other cycle double the period
        @(negedge clk);
        fm_sel = 1'b0; am_swallow = 1'b0; ratio_word = 16'h0050;
        wait_fp();
        lo_half = 1'b1;
        wait_fp();
        fp_interval(per);
        check(per == 10, "R8 half-rate ticks", per, 10);
        @(negedge clk);
        check(fp == 1'b0, "R8 single-cycle fp", int'(fp), 0);
        lo_half = 1'b0;

        // R5: ratio change mid-period
        wait_fp();
        wait_fp();
        per = 0;
        for (int n = 0; n < 1000; n++) begin
            @(negedge clk);
            per++;
            if (per == 2) ratio_word = 16'd1600;
            if (fp) break;
        end
        check(per == 5, "R5 old ratio completes", per, 5);
        per = 0;
        for (int n = 0; n < 1000; n++) begin
            @(negedge clk);
            per++;
            if (per == 3) begin fm_sel = 1'b1; ratio_word = 16'd300; end
            if (fp) break;
        end
        check(per == 100, "R5 new ratio after terminal", per, 100);
        fp_interval(per);
        check(per == 300, "R5 mode change after terminal", per, 300);

        // R6: reference ratios for both crystals
        ref_case(4'b0000, 1'b1, 72);
        ref_case(4'b0110, 1'b1, 2304);
        ref_case(4'b1001, 1'b1, 800);
        ref_case(4'b1101, 1'b0, 150);
        ref_case(4'b0011, 1'b0, 180);
        ref_case(4'b1011, 1'b0, 4500);

        // R7: inhibit codes
        @(negedge clk);
        ref_code = 4'b1110;
        @(negedge clk);
        check(pll_off && osc_stop, "R7 code 1110 flags", {pll_off, osc_stop}, 3);
        nfp = 0; nfr = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (fp) nfp++;
            if (fr) nfr++;
        end
        check(nfp + nfr == 0, "R7 no pulses while inhibited", nfp + nfr, 0);
        ref_code = 4'b1111;
        fm_sel = 1'b0; am_swallow = 1'b0; ratio_word = 16'h0050; xtal_hi = 1'b1;
        @(negedge clk);
        check(pll_off && !osc_stop, "R7 code 1111 flags", {pll_off, osc_stop}, 2);
        @(negedge clk);
        ref_code = 4'b0000;
        first_fp = 0;
        first_fr = 0;
        for (int n = 1; n <= 100; n++) begin
            @(negedge clk);
            if (fp && first_fp == 0) first_fp = n;
            if (fr && first_fr == 0) first_fr = n;
        end
        check(first_fp == 5, "R7 fp restarts from zero", first_fp, 5);
        check(first_fr == 72, "R7 fr restarts from zero", first_fr, 72);
        check(!pll_off, "R7 released", int'(pll_off), 0);

        finish_run();
    end
endmodule